// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core and presents the core with one registered request line and a vector number. Two kinds of sources feed it. Event sources set a sticky flag that stays set until the request is serviced or software clears it. Condition sources request service only while their input is high and keep no memory. Each source has its own enable bit. A single global enable bit gates every source. The core also sees this bit as part of its status word.

When the global enable is set and one or more enabled sources are pending, the controller raises its request with the vector of the winning source. The lowest vector number has the highest priority. Vector 0 is kept for reset and is never issued. The event sources take vectors 1 to NE, and the condition sources follow them. The core accepts the vector with an acknowledge strobe. On acknowledge the controller clears the global enable and, for an event source, that source's flag. A return strobe sets the global enable again, and then a guard window of one instruction slot must pass before a new request can be raised. Software uses a small register port to set or clear the global enable, to program the enables and to clear flags.

Top module: `prio_vic`

## Requirements
- R1: After reset, irq_o is 0, irq_vec_o is 0, and every register reads 0.
- R2: When several enabled sources are pending, the vector issued is the lowest pending vector number. Event source i has vector i+1. Condition source j has vector NE+1+j.
- R3: A source is issued only when its enable bit and the global enable are both 1.
- R4: An accepted acknowledge clears the global enable. A return strobe sets it to 1.
- R5: An acknowledge of an event vector clears that source's flag. Writing 1 to a flag bit at address 2 clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R6: An event that arrives while its source is disabled, or while the global enable is 0, stays flagged. Flags pending together are served one after another in priority order.
- R7: A condition source is issued only while its input is high. If the input goes low before the source is enabled, nothing is ever issued for it.
- R8: After the cycle in which irq_ret_i is sampled, irq_o stays 0 for two clock cycles. The earliest new request appears in the third cycle.
- R9: A register write that clears the global enable withdraws irq_o in the next cycle. No request is raised from that cycle on, even for a request that arrives in the same cycle as the write.
- R10: If software sets the global enable inside a handler, any enabled pending source is issued (nested interrupt).
- R11: Once irq_o is high, irq_o and irq_vec_o stay unchanged until irq_ack_i, even if a higher-priority request arrives.
- R12: Register map. Address 0 bit 0 is the global enable, and writing 1 or 0 sets or clears it. Address 1 bit k is the enable for vector k+1. Address 2 bit i is the flag of event source i. Address 3 reads 0.
- R13: An event that arrives in the same cycle as a write-1 clear of its flag, or as its acknowledge, stays flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt_i | input | NE | Event inputs; a high cycle sets the flag |
| src_cond_i | input | NC | Condition (level) request inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |
| irq_o | output | 1 | Registered interrupt request to the core |
| irq_vec_o | output | VW | Vector number of the request; 0 when idle |
| irq_ack_i | input | 1 | Core accepts the vector |
| irq_ret_i | input | 1 | Core executes return-from-interrupt |

## Verification
The bench sweeps every combination of the four event flags raised together and computes the service order from the lowest set bit. A controller with the priority reversed, or one that loses a flag on acknowledge, issues the wrong vector or leaves stale flags in the readback. The return guard is timed cycle by cycle, so a controller that accepts a request one slot too early is caught. The bench also checks a global-enable clear that coincides with a new condition request, which a controller that decides on the old enable value would take. It also covers flags written or acknowledged in the same cycle as a new event, which an ordering that clears last would lose, and a condition request that drops before it is enabled, which a controller that latches conditions would still serve.

// File: rtl/prio_vic_pkg.sv
package prio_vic_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_FLAG = 2'd2;

  // lowest set bit of pend, returned as vector number (index + 1); 0 if none
  function automatic int unsigned lowest_vec(input logic [31:0] pend, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(n) && pend[i]) r = i + 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/prio_vic_flags.sv
module prio_vic_flags #(
  parameter int NE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt_i,
  input  logic [NE-1:0] w1c_i,
  input  logic [NE-1:0] ack_clr_i,
  output logic [NE-1:0] flags_o
);
  logic [NE-1:0] flags_q;

  // clears act first, new events last, so no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~w1c_i & ~ack_clr_i) | evt_i;
  end

  assign flags_o = flags_q;

  AST_EVT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((flags_q & $past(evt_i)) == $past(evt_i))); // R13
  AST_NO_SPONT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q) & ~$past(evt_i)) == '0)); // R6
endmodule

// File: rtl/prio_vic_arbiter.sv
module prio_vic_arbiter
  import prio_vic_pkg::*;
#(
  parameter int N  = 7,
  parameter int VW = 3
) (
  input  logic [N-1:0]  pend_i,
  output logic [VW-1:0] win_o,
  output logic          any_o
);
  logic [31:0] pend_ext;

  assign pend_ext = 32'(pend_i);
  assign win_o    = VW'(lowest_vec(pend_ext, N));
  assign any_o    = |pend_i;
endmodule

// File: rtl/prio_vic.sv
module prio_vic
  import prio_vic_pkg::*;
#(
  parameter int NE = 4,
  parameter int NC = 3,
  parameter int DW = 8,
  localparam int NSRC = NE + NC,
  localparam int VW = $clog2(NSRC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] src_evt_i,
  input  logic [NC-1:0] src_cond_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_o,
  output logic [VW-1:0] irq_vec_o,
  input  logic          irq_ack_i,
  input  logic          irq_ret_i
);
  logic            gie_q, irq_q, blk_q;
  logic [NSRC-1:0] en_q;
  logic [VW-1:0]   vec_q;
  logic [NE-1:0]   flags, w1c, ack_clr;
  logic [NSRC-1:0] pend;
  logic [VW-1:0]   win;
  logic            any_pend;

  // named events for the assertions
  logic wr_ctrl, clr_gie, set_gie, ack_take, take;

  assign wr_ctrl  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign clr_gie  = wr_ctrl && !reg_wdata_i[0];
  assign set_gie  = wr_ctrl && reg_wdata_i[0];
  assign ack_take = irq_q && irq_ack_i;
  assign w1c      = (reg_we_i && reg_addr_i == ADDR_FLAG) ? reg_wdata_i[NE-1:0] : '0;

  genvar g;
  generate
    for (g = 0; g < NE; g++) begin : g_ackclr
      assign ack_clr[g] = ack_take && (vec_q == VW'(g + 1));
    end
  endgenerate

  prio_vic_flags #(.NE(NE)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(src_evt_i), .w1c_i(w1c),
    .ack_clr_i(ack_clr), .flags_o(flags)
  );

  assign pend = {src_cond_i, flags} & en_q;

  prio_vic_arbiter #(.N(NSRC), .VW(VW)) u_arb (
    .pend_i(pend), .win_o(win), .any_o(any_pend)
  );

  assign take = !irq_q && gie_q && !clr_gie && !irq_ret_i && !blk_q && any_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      en_q  <= '0;
      irq_q <= 1'b0;
      vec_q <= '0;
      blk_q <= 1'b0;
    end else begin
      blk_q <= irq_ret_i;
      if (reg_we_i && reg_addr_i == ADDR_EN) en_q <= reg_wdata_i[NSRC-1:0];
      if (clr_gie)        gie_q <= 1'b0;
      else if (set_gie)   gie_q <= 1'b1;
      else if (ack_take)  gie_q <= 1'b0;
      else if (irq_ret_i) gie_q <= 1'b1;
      if (clr_gie || ack_take) begin
        irq_q <= 1'b0;
        vec_q <= '0;
      end else if (take) begin
        irq_q <= 1'b1;
        vec_q <= win;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o[0] = gie_q;
      ADDR_EN:   reg_rdata_o = DW'(en_q);
      ADDR_FLAG: reg_rdata_o = DW'(flags);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o     = irq_q;
  assign irq_vec_o = vec_q;

  AST_ENTRY_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !set_gie) |=> !gie_q); // R4
  AST_RET_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret_i && !irq_q) |=> !irq_q ##1 !irq_q); // R8
  AST_CLR_GIE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr_gie |=> (!irq_q && !gie_q)); // R9
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack_i && !clr_gie) |=> (irq_q && $stable(vec_q))); // R11
  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(gie_q)); // R3
  AST_VEC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (vec_q != '0 && int'(vec_q) <= NSRC)); // R2
endmodule

// File: tb/prio_vic_tb.sv
module prio_vic_tb;
  localparam int NE = 4;
  localparam int NC = 3;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] src_evt = '0;
  logic [NC-1:0] src_cond = '0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;
  logic [2:0]    irq_vec;
  logic          ack = 1'b0;
  logic          ret = 1'b0;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prio_vic #(.NE(NE), .NC(NC), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt), .src_cond_i(src_cond),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq), .irq_vec_o(irq_vec),
    .irq_ack_i(ack), .irq_ret_i(ret)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NE-1:0] m);
    src_evt = m;
    step();
    src_evt = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic do_ret();
    ret = 1'b1; step(); ret = 1'b0;
  endtask

  task automatic wait_irq(input int n);
    for (int i = 0; i < n && !irq; i++) step();
  endtask

  function automatic int low_vec(input int m);
    for (int i = 0; i < 8; i++) if (m[i]) return i + 1;
    return 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int rem, ex;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk(irq == 0 && irq_vec == 0, "R1 irq idle", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(d == 0, "R1 reg zero", int'(d), 0);
    end

    // R12 register map
    wr(1, 8'h55); rd(1, d); chk(d == 8'h55, "R12 enable readback", int'(d), 8'h55);
    rd(3, d); chk(d == 0, "R12 addr3", int'(d), 0);
    wr(0, 8'h01); rd(0, d); chk(d == 8'h01, "R12 gie set", int'(d), 1);
    wr(0, 8'h00); rd(0, d); chk(d == 8'h00, "R12 gie clr", int'(d), 0);

    // R2 R4 R5 R6: sweep every combination of event flags
    for (int m = 1; m < 16; m++) begin
      wr(2, 8'hFF); wr(0, 8'h00);
      pulse(4'(m));
      rd(2, d); chk(d == 8'(m), "R6 latched while gie off", int'(d), m);
      wr(1, 8'h7F); wr(0, 8'h01);
      rem = m;
      while (rem != 0) begin
        ex = low_vec(rem);
        wait_irq(6);
        chk(irq == 1 && int'(irq_vec) == ex, "R2 priority vector", int'(irq_vec), ex);
        do_ack();
        rd(0, d); chk(d[0] == 0, "R4 entry clears gie", int'(d[0]), 0);
        rem = rem & ~(1 << (ex - 1));
        rd(2, d); chk(int'(d) == rem, "R5 ack clears flag", int'(d), rem);
        do_ret();
        rd(0, d); chk(d[0] == 1, "R4 return sets gie", int'(d[0]), 1);
      end
      step(); step(); step();
      chk(irq == 0, "R6 all served", int'(irq), 0);
    end

    // R8 return guard timing
    wr(2, 8'hFF); wr(0, 8'h00);
    pulse(4'b0011);
    wr(1, 8'h7F); wr(0, 8'h01);
    wait_irq(6);
    chk(irq_vec == 1, "R8 setup", int'(irq_vec), 1);
    do_ack();
    do_ret();
    chk(irq == 0, "R8 guard cycle 1", int'(irq), 0);
    step();
    chk(irq == 0, "R8 guard cycle 2", int'(irq), 0);
    step();
    chk(irq == 1 && irq_vec == 2, "R8 taken after guard", int'(irq_vec), 2);
    do_ack(); do_ret();

    // R7 condition sources
    wr(2, 8'hFF); wr(0, 8'h00); wr(1, 8'h7F);
    src_cond = 3'b010;
    wr(0, 8'h01);
    wait_irq(6);
    chk(irq == 1 && int'(irq_vec) == NE + 2, "R7 condition vector", int'(irq_vec), NE + 2);
    do_ack();
    src_cond = '0;
    do_ret();
    step(); step(); step();
    chk(irq == 0, "R7 no memory after drop", int'(irq), 0);
    wr(0, 8'h00); wr(1, 8'h00);
    src_cond = 3'b001;
    step();
    src_cond = '0;
    wr(1, 8'h7F); wr(0, 8'h01);
    step(); step(); step();
    chk(irq == 0, "R7 dropped before enable", int'(irq), 0);

    // R3 individual enable and global enable
    wr(1, 8'h00);
    pulse(4'b0001);
    step(); step(); step();
    chk(irq == 0, "R3 source disabled", int'(irq), 0);
    rd(2, d); chk(d == 1, "R6 latched while disabled", int'(d), 1);
    wr(1, 8'h01);
    wait_irq(6);
    chk(irq == 1 && irq_vec == 1, "R3 enabled later", int'(irq_vec), 1);
    do_ack(); do_ret();
    wr(1, 8'h7F); wr(0, 8'h00);
    pulse(4'b0001);
    step(); step(); step();
    chk(irq == 0, "R3 gie off", int'(irq), 0);
    wr(0, 8'h01);
    wait_irq(6);
    chk(irq == 1 && irq_vec == 1, "R3 gie on", int'(irq_vec), 1);
    do_ack(); do_ret();

    // R5 write 0 leaves flags
    wr(2, 8'hFF); wr(0, 8'h00);
    pulse(4'b0110);
    wr(2, 8'h02); rd(2, d); chk(d == 8'h04, "R5 w1c one bit", int'(d), 4);
    wr(2, 8'h00); rd(2, d); chk(d == 8'h04, "R5 write zero no effect", int'(d), 4);
    wr(2, 8'hFF);

    // R13 event together with its clear
    src_evt = 4'b0001;
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h01;
    step();
    src_evt = '0; reg_we = 1'b0;
    rd(2, d); chk(d == 8'h01, "R13 event beats w1c", int'(d), 1);
    wr(2, 8'hFF);
    pulse(4'b0001);
    wr(0, 8'h01);
    wait_irq(6);
    src_evt = 4'b0001; ack = 1'b1;
    step();
    src_evt = '0; ack = 1'b0;
    rd(2, d); chk(d == 8'h01, "R13 event beats ack clear", int'(d), 1);
    do_ret(); wait_irq(6); do_ack(); do_ret();

    // R9 clear of global enable
    wr(2, 8'hFF); wr(0, 8'h01);
    pulse(4'b0010);
    wait_irq(6);
    chk(irq == 1 && irq_vec == 2, "R9 setup", int'(irq_vec), 2);
    wr(0, 8'h00);
    chk(irq == 0, "R9 request withdrawn", int'(irq), 0);
    rd(0, d); chk(d[0] == 0, "R9 gie cleared", int'(d[0]), 0);
    rd(2, d); chk(d == 8'h02, "R9 flag kept", int'(d), 2);
    wr(2, 8'hFF); wr(0, 8'h01); step();
    src_cond = 3'b100;
    wr(0, 8'h00);
    chk(irq == 0, "R9 same-cycle arrival", int'(irq), 0);
    step(); step();
    chk(irq == 0, "R9 none after clear", int'(irq), 0);
    src_cond = '0;

    // R11 held until acknowledge
    wr(0, 8'h01);
    pulse(4'b0100);
    wait_irq(6);
    pulse(4'b0001);
    for (int k = 0; k < 4; k++) begin
      chk(irq == 1 && irq_vec == 3, "R11 vector held", int'(irq_vec), 3);
      step();
    end
    do_ack();
    rd(2, d); chk(d == 8'h01, "R11 only taken flag cleared", int'(d), 1);
    do_ret(); wait_irq(6);
    chk(irq_vec == 1, "R11 next vector", int'(irq_vec), 1);
    do_ack(); do_ret();

    // R10 nesting by setting gie inside a handler
    wr(2, 8'hFF); wr(0, 8'h00);
    pulse(4'b1000);
    wr(0, 8'h01);
    wait_irq(6);
    chk(irq_vec == 4, "R10 outer", int'(irq_vec), 4);
    do_ack();
    pulse(4'b0010);
    step(); step();
    chk(irq == 0, "R10 blocked in handler", int'(irq), 0);
    wr(0, 8'h01);
    wait_irq(6);
    chk(irq == 1 && irq_vec == 2, "R10 nested taken", int'(irq_vec), 2);
    do_ack(); do_ret(); do_ret();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule